// File: doc/BRIEF.md
# Video Scanline Mode Timing Generator

This block produces the dot-rate timing skeleton of a small handheld-style video unit. On every qualified dot tick it advances a dot position within the current scanline and a line number within the frame. From those two counters it derives a two-bit mode code that tells the rest of the video pipeline, and any status logic, which phase of the line is active: object scan, pixel transfer, horizontal blank or vertical blank.

Alongside the levels it emits single-clock event pulses when the mode changes, when a line's drawing phase ends (horizontal blank entry), when vertical blank begins and when the frame wraps. A sticky frame-ready flag lets a host notice a completed frame and clear it with a strobe. Turning the display on (or holding it off) puts the counters in a special starting position: the first line begins four dots late and shows horizontal blank instead of object scan for its opening stretch. A flag marking that first line is exported so that downstream status logic can treat it specially.

Top module: `vid_line_timer`

## Requirements
- R1: The dot position counts 0 to 455 and wraps to 0 on the tick after 455; each wrap advances the line number by one.
- R2: The line number counts 0 to 153 and wraps to 0 on the tick that ends line 153.
- R3: Outside the first line, mode code 2 (object scan) is shown for dots 0 to 79, code 3 (pixel transfer) for dots 80 to 251 and code 0 (horizontal blank) for dots 252 to 455 on lines 0 to 143.
- R4: On lines 144 to 153 the mode code is 1 (vertical blank) at every dot position.
- R5: While rst_n is low or disp_en is low, dot_pos is 4, line_no is 0, mode is 0, first_line is 1, frame_ready is 0 and every event output is 0.
- R6: On the first line after enable, dots below 80 show mode 0 and dot 80 moves straight to mode 3; first_line is 1 until line_no leaves 0 and 0 after that, so the first line lasts 452 ticks.
- R7: ev_mode_chg is 1 for exactly the clock after a tick that changes the mode; ev_render accompanies it when the new mode is 0 and ev_vblank when the new mode is 1.
- R8: ev_frame pulses for one clock when the line number wraps from 153 to 0, and frame_ready rises with it; after enable this happens on tick 70,220.
- R9: frame_ready stays 1 until a ready_clr strobe (with or without a tick); when the strobe and a frame wrap coincide, frame_ready ends up 1.
- R10: On a clock without dot_tick, dot_pos, line_no, mode and first_line hold and no event output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Display enable; low holds the start position |
| dot_tick | input | 1 | Advance one dot on this clock |
| ready_clr | input | 1 | Clear strobe for frame_ready |
| mode | output | 2 | Mode code: 0 h-blank, 1 v-blank, 2 object scan, 3 pixel transfer |
| line_no | output | 8 | Current line number |
| dot_pos | output | 9 | Current dot within the line |
| first_line | output | 1 | High during the first line after enable |
| ev_mode_chg | output | 1 | One-clock pulse on a mode change |
| ev_render | output | 1 | One-clock pulse on horizontal blank entry |
| ev_vblank | output | 1 | One-clock pulse on vertical blank entry |
| ev_frame | output | 1 | One-clock pulse on the frame wrap |
| frame_ready | output | 1 | Sticky frame-complete flag |

## Verification
The assertions take for granted that dot_tick, disp_en and ready_clr are stable single-bit levels sampled at the clock edge, and that display enable is only raised from the held start state; they make no assumption about how ticks are spaced. The stimulus keeps to this by changing every input a fixed time after the rising edge, mixing tick gaps with long unbroken tick runs, dropping disp_en only for whole cycles, and placing the clear strobe both on a quiet cycle and exactly on the wrapping tick.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_DRAW   = 2'd3
  } vmode_t;

  typedef struct packed {
    logic mode_chg;
    logic render;
    logic vblank;
    logic frame;
  } vevt_t;

  localparam vevt_t EVT_NONE = '{mode_chg: 1'b0, render: 1'b0, vblank: 1'b0, frame: 1'b0};

endpackage

// File: rtl/vlt_dot_ctr.sv
module vlt_dot_ctr #(
  parameter int LINE_DOTS = 456,
  parameter int START_DOT = 4,
  localparam int DW = $clog2(LINE_DOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  output logic [DW-1:0] dot,
  output logic [DW-1:0] dot_nxt,
  output logic          dot_wrap
);

  localparam logic [DW-1:0] DOT_LAST  = DW'(LINE_DOTS - 1);
  localparam logic [DW-1:0] DOT_START = DW'(START_DOT);

  // next-position arithmetic kept in a function
  function automatic logic [DW-1:0] advance(input logic [DW-1:0] d);
    return (d == DOT_LAST) ? '0 : d + DW'(1);
  endfunction

  assign dot_wrap = (dot == DOT_LAST);
  assign dot_nxt  = advance(dot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dot <= DOT_START;
    else if (!enable) dot <= DOT_START;
    else if (tick)    dot <= dot_nxt;
  end

endmodule

// File: rtl/vlt_line_ctr.sv
module vlt_line_ctr #(
  parameter int FRAME_LINES = 154,
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          dot_wrap,
  output logic [LW-1:0] line,
  output logic [LW-1:0] line_nxt,
  output logic          first_q,
  output logic          frame_wrap
);

  localparam logic [LW-1:0] LINE_LAST = LW'(FRAME_LINES - 1);

  function automatic logic [LW-1:0] next_line(input logic [LW-1:0] l, input logic step);
    if (!step)          return l;
    if (l == LINE_LAST) return '0;
    return l + LW'(1);
  endfunction

  assign line_nxt   = next_line(line, dot_wrap);
  assign frame_wrap = dot_wrap && (line == LINE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line    <= '0;
      first_q <= 1'b1;
    end else if (!enable) begin
      line    <= '0;
      first_q <= 1'b1;
    end else if (tick) begin
      line    <= line_nxt;
      first_q <= first_q && (line_nxt == '0);
    end
  end

endmodule

// File: rtl/vlt_mode_dec.sv
module vlt_mode_dec #(
  parameter int LINE_DOTS   = 456,
  parameter int FRAME_LINES = 154,
  parameter int VBL_LINE    = 144,
  parameter int SCAN_DOTS   = 80,
  parameter int DRAW_DOTS   = 172,
  parameter bit LATE_FIRST  = 1'b1,
  localparam int DW = $clog2(LINE_DOTS),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic [DW-1:0]  dot,
  input  logic [LW-1:0]  line,
  input  logic           first,
  output vlt_pkg::vmode_t mode
);
  import vlt_pkg::*;

  localparam logic [DW-1:0] SCAN_END = DW'(SCAN_DOTS);
  localparam logic [DW-1:0] DRAW_END = DW'(SCAN_DOTS + DRAW_DOTS);
  localparam logic [LW-1:0] VBL_FROM = LW'(VBL_LINE);

  // mode code for a position on a normal line
  function automatic vmode_t plain_mode(input logic [DW-1:0] d, input logic [LW-1:0] l);
    if (l >= VBL_FROM)  return MODE_VBLANK;
    if (d <  SCAN_END)  return MODE_SCAN;
    if (d <  DRAW_END)  return MODE_DRAW;
    return MODE_HBLANK;
  endfunction

  vmode_t base_mode;
  assign base_mode = plain_mode(dot, line);

  generate
    if (LATE_FIRST) begin : g_late_first
      // first line after enable shows blank in place of object scan
      always_comb begin
        if (first && (line == '0) && (base_mode == MODE_SCAN)) mode = MODE_HBLANK;
        else                                                   mode = base_mode;
      end
    end else begin : g_plain
      always_comb mode = base_mode;
    end
  endgenerate

endmodule

// File: rtl/vlt_evt_gen.sv
module vlt_evt_gen (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            tick,
  input  vlt_pkg::vmode_t mode_nxt,
  input  logic            frame_wrap,
  input  logic            ready_clr,
  output vlt_pkg::vmode_t mode_q,
  output vlt_pkg::vevt_t  evt_q,
  output logic            ready_q
);
  import vlt_pkg::*;

  function automatic vevt_t classify(input vmode_t old_m, input vmode_t new_m, input logic wrap);
    vevt_t e;
    e.mode_chg = (old_m != new_m);
    e.render   = e.mode_chg && (new_m == MODE_HBLANK);
    e.vblank   = e.mode_chg && (new_m == MODE_VBLANK);
    e.frame    = wrap;
    return e;
  endfunction

  vevt_t evt_d;
  logic  ready_d;

  always_comb begin
    evt_d   = tick ? classify(mode_q, mode_nxt, frame_wrap) : EVT_NONE;
    // a set on the wrapping tick outranks the clear strobe
    ready_d = evt_d.frame | (ready_q & ~ready_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_HBLANK;
      evt_q   <= EVT_NONE;
      ready_q <= 1'b0;
    end else if (!enable) begin
      mode_q  <= MODE_HBLANK;
      evt_q   <= EVT_NONE;
      ready_q <= 1'b0;
    end else begin
      evt_q   <= evt_d;
      ready_q <= ready_d;
      if (tick) mode_q <= mode_nxt;
    end
  end

endmodule

// File: rtl/vid_line_timer.sv
module vid_line_timer #(
  parameter int LINE_DOTS   = 456,
  parameter int FRAME_LINES = 154,
  parameter int VBL_LINE    = 144,
  parameter int SCAN_DOTS   = 80,
  parameter int DRAW_DOTS   = 172,
  parameter int START_DOT   = 4,
  parameter bit LATE_FIRST  = 1'b1,
  localparam int DW = $clog2(LINE_DOTS),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_en,
  input  logic          dot_tick,
  input  logic          ready_clr,
  output logic [1:0]    mode,
  output logic [LW-1:0] line_no,
  output logic [DW-1:0] dot_pos,
  output logic          first_line,
  output logic          ev_mode_chg,
  output logic          ev_render,
  output logic          ev_vblank,
  output logic          ev_frame,
  output logic          frame_ready
);
  import vlt_pkg::*;

  // named internal events, visible to the bound checker
  logic [DW-1:0] dot_nxt;
  logic          dot_wrap;
  logic [LW-1:0] line_nxt;
  logic          frame_wrap;
  vmode_t        mode_nxt;
  vmode_t        mode_q;
  vevt_t         evt_q;

  vlt_dot_ctr #(.LINE_DOTS(LINE_DOTS), .START_DOT(START_DOT)) u_dot (
    .clk(clk), .rst_n(rst_n), .enable(disp_en), .tick(dot_tick),
    .dot(dot_pos), .dot_nxt(dot_nxt), .dot_wrap(dot_wrap)
  );

  vlt_line_ctr #(.FRAME_LINES(FRAME_LINES)) u_line (
    .clk(clk), .rst_n(rst_n), .enable(disp_en), .tick(dot_tick),
    .dot_wrap(dot_wrap), .line(line_no), .line_nxt(line_nxt),
    .first_q(first_line), .frame_wrap(frame_wrap)
  );

  vlt_mode_dec #(
    .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES), .VBL_LINE(VBL_LINE),
    .SCAN_DOTS(SCAN_DOTS), .DRAW_DOTS(DRAW_DOTS), .LATE_FIRST(LATE_FIRST)
  ) u_dec (
    .dot(dot_nxt), .line(line_nxt), .first(first_line), .mode(mode_nxt)
  );

  vlt_evt_gen u_evt (
    .clk(clk), .rst_n(rst_n), .enable(disp_en), .tick(dot_tick),
    .mode_nxt(mode_nxt), .frame_wrap(frame_wrap), .ready_clr(ready_clr),
    .mode_q(mode_q), .evt_q(evt_q), .ready_q(frame_ready)
  );

  assign mode        = mode_q;
  assign ev_mode_chg = evt_q.mode_chg;
  assign ev_render   = evt_q.render;
  assign ev_vblank   = evt_q.vblank;
  assign ev_frame    = evt_q.frame;

endmodule

// File: rtl/vlt_checker.sv
module vlt_checker #(
  parameter int LINE_DOTS   = 456,
  parameter int FRAME_LINES = 154,
  parameter int VBL_LINE    = 144,
  parameter int SCAN_DOTS   = 80,
  parameter int START_DOT   = 4,
  localparam int DW = $clog2(LINE_DOTS),
  localparam int LW = $clog2(FRAME_LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          disp_en,
  input logic          dot_tick,
  input logic          ready_clr,
  input logic [1:0]    mode,
  input logic [LW-1:0] line_no,
  input logic [DW-1:0] dot_pos,
  input logic          first_line,
  input logic          ev_mode_chg,
  input logic          ev_render,
  input logic          ev_vblank,
  input logic          ev_frame,
  input logic          frame_ready,
  input logic          dot_wrap,
  input logic          frame_wrap
);

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= disp_en;
  end

  a_r1_dot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dot_pos < DW'(LINE_DOTS));

  a_r1_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && disp_en && $past(dot_tick) && !$past(dot_wrap) |-> dot_pos == $past(dot_pos) + DW'(1));

  a_r2_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    line_no < LW'(FRAME_LINES));

  a_r4_vblank_lines: assert property (@(posedge clk) disable iff (!rst_n)
    line_no >= LW'(VBL_LINE) |-> mode == 2'd1);

  a_r5_held_start: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> dot_pos == DW'(START_DOT) && line_no == '0 && mode == 2'd0 && !ev_mode_chg && !frame_ready);

  a_r6_first_blank: assert property (@(posedge clk) disable iff (!rst_n)
    first_line && dot_pos < DW'(SCAN_DOTS) |-> mode == 2'd0);

  a_r6_first_line0: assert property (@(posedge clk) disable iff (!rst_n)
    first_line |-> line_no == '0);

  a_r7_render_kind: assert property (@(posedge clk) disable iff (!rst_n)
    ev_render |-> ev_mode_chg && mode == 2'd0);

  a_r7_vblank_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vblank |-> ev_mode_chg && mode == 2'd1 && line_no == LW'(VBL_LINE) && dot_pos == '0);

  a_r8_frame_pos: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |-> frame_ready && line_no == '0 && dot_pos == '0);

  a_r8_frame_src: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && disp_en && $past(dot_tick) && $past(frame_wrap) |-> ev_frame);

  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && disp_en && $past(frame_ready) && !$past(ready_clr) |-> frame_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && disp_en && !$past(dot_tick) |-> $stable(dot_pos) && $stable(line_no) && $stable(mode)
      && !ev_mode_chg && !ev_frame);

endmodule

bind vid_line_timer vlt_checker #(
  .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES), .VBL_LINE(VBL_LINE),
  .SCAN_DOTS(SCAN_DOTS), .START_DOT(START_DOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .dot_tick(dot_tick), .ready_clr(ready_clr),
  .mode(mode), .line_no(line_no), .dot_pos(dot_pos), .first_line(first_line),
  .ev_mode_chg(ev_mode_chg), .ev_render(ev_render), .ev_vblank(ev_vblank),
  .ev_frame(ev_frame), .frame_ready(frame_ready), .dot_wrap(dot_wrap), .frame_wrap(frame_wrap)
);

// File: tb/vid_line_timer_bench.sv
`timescale 1ns/1ps
module vid_line_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_en = 1'b0;
  logic       dot_tick = 1'b0;
  logic       ready_clr = 1'b0;
  logic [1:0] mode;
  logic [7:0] line_no;
  logic [8:0] dot_pos;
  logic       first_line, ev_mode_chg, ev_render, ev_vblank, ev_frame, frame_ready;

  always #4 clk = ~clk;

  vid_line_timer u_vid_line_timer (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .dot_tick(dot_tick), .ready_clr(ready_clr),
    .mode(mode), .line_no(line_no), .dot_pos(dot_pos), .first_line(first_line),
    .ev_mode_chg(ev_mode_chg), .ev_render(ev_render), .ev_vblank(ev_vblank),
    .ev_frame(ev_frame), .frame_ready(frame_ready)
  );

  typedef struct {
    bit     en;
    bit     tick;
    int     dot, line, md, first, chg, rnd, vbl, frm, rdy;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  // reference state: dots elapsed since the start of line 0 of the first frame
  longint pos;
  int     m_mode;
  int     m_rdy;

  task automatic cmp(input string tag, input int act, input int exv);
    n_cmp++;
    if (act != exv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exv, $time);
    end
  endtask

  function automatic int ref_mode(input longint p);
    int d, l;
    d = int'(p % 456);
    l = int'((p / 456) % 154);
    if (l >= 144) return 1;
    if (d < 80)   return (p < 456) ? 0 : 2;
    if (d < 252)  return 3;
    return 0;
  endfunction

  // driver: one clock, inputs applied after the edge, expectation queued
  task automatic step(input bit en, input bit tk, input bit clr);
    exp_t e;
    int   nm;
    @(posedge clk);
    #2;
    disp_en = en; dot_tick = tk; ready_clr = clr;
    e.en = en; e.tick = tk;
    e.chg = 0; e.rnd = 0; e.vbl = 0; e.frm = 0;
    if (!en) begin
      pos = 4; m_mode = 0; m_rdy = 0;
    end else if (tk) begin
      pos++;
      nm = ref_mode(pos);
      if (nm != m_mode) begin
        e.chg = 1; e.rnd = (nm == 0); e.vbl = (nm == 1);
      end
      m_mode = nm;
      e.frm = (pos % (456 * 154) == 0) ? 1 : 0;
      m_rdy = (e.frm == 1 || (m_rdy == 1 && !clr)) ? 1 : 0;
    end else begin
      m_rdy = (m_rdy == 1 && !clr) ? 1 : 0;
    end
    e.dot = int'(pos % 456); e.line = int'((pos / 456) % 154);
    e.md = m_mode; e.first = (pos < 456) ? 1 : 0; e.rdy = m_rdy;
    exp_q.push_back(e);
  endtask

  // monitor: compares one queued item per clock, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string tpos, tline, tmode;
        e = exp_q.pop_front();
        tpos  = !e.en ? "R5" : (!e.tick ? "R10" : "R1");
        tline = !e.en ? "R5" : (!e.tick ? "R10" : "R2");
        tmode = !e.en ? "R5" : (e.line >= 144 ? "R4" : (e.first == 1 ? "R6" : "R3"));
        cmp({tpos, " dot"}, int'(dot_pos), e.dot);
        cmp({tline, " line"}, int'(line_no), e.line);
        cmp({tmode, " mode"}, int'(mode), e.md);
        cmp(!e.en ? "R5 first_line" : "R6 first_line", int'(first_line), e.first);
        cmp(!e.tick ? "R10 ev_mode_chg" : "R7 ev_mode_chg", int'(ev_mode_chg), e.chg);
        cmp("R7 ev_render", int'(ev_render), e.rnd);
        cmp("R7 ev_vblank", int'(ev_vblank), e.vbl);
        cmp(!e.tick ? "R10 ev_frame" : "R8 ev_frame", int'(ev_frame), e.frm);
        cmp(!e.en ? "R5 frame_ready" : "R9 frame_ready", int'(frame_ready), e.rdy);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pos = 4; m_mode = 0; m_rdy = 0;
    repeat (3) @(posedge clk);
    #2;
    // R5: held start state during reset
    cmp("R5 reset dot", int'(dot_pos), 4);
    cmp("R5 reset line", int'(line_no), 0);
    cmp("R5 reset mode", int'(mode), 0);
    cmp("R5 reset first_line", int'(first_line), 1);
    cmp("R5 reset frame_ready", int'(frame_ready), 0);
    rst_n = 1'b1;

    // gapped ticks through the first line (R6 blank-then-draw, R10 holds)
    for (int i = 0; i < 700; i++) step(1, (i % 5) != 3, 0);
    // display off mid-line (R5), then on again
    for (int i = 0; i < 3; i++) step(0, 1, 0);
    // one full frame with unbroken ticks: 70,220 ticks to the wrap (R8)
    for (int i = 0; i < 70220; i++) step(1, 1, 0);
    // flag holds while idle (R9), then a quiet-cycle clear
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    step(1, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 1, 0);
    // run to the next wrap, clear strobe on the wrapping tick: set wins (R9)
    for (int i = 0; i < 70224 - 4; i++) step(1, 1, 0);
    step(1, 1, 1);
    step(1, 1, 0);
    step(1, 0, 0);
    @(posedge clk);
    @(posedge clk);
    #2;
    // R8: explicit view after the second wrap
    cmp("R8 line after wrap", int'(line_no), 0);
    cmp("R9 ready after clear-and-wrap", int'(frame_ready), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule